// File: doc/BRIEF.md
# Serial EEPROM Access Sequencer

This block turns single memory requests into the ordered command stream that a two-wire serial EEPROM expects. It sits above an I2C master byte engine. For each command it hands the engine one primitive: a START condition, which also serves as a repeated START, a byte to transmit, a byte to receive, or a STOP condition. It then waits for the engine to report that the command has completed before it issues the next one. A request carries a memory address, a write flag, one data byte for writes, and a length for reads. Read bytes come back one at a time with a valid strobe.

The bus gives no way to tell which addressing scheme a device uses, so a parameter fixes it when the block is built. In compact mode, the top three bits of an 11-bit memory address ride in the device-select byte, and a single address byte follows. In extended mode, the select byte carries three fixed chip-select bits taken from a parameter, and a 16-bit address follows, high byte first. A device that refuses any transmitted byte ends the transaction at once with a STOP and raises an error flag.

Top module: `eeprom_seq`

## Requirements
- R1: While reset is asserted and after it is released, busy, done, err, rd_valid and cmd_valid are all 0.
- R2: In compact mode (EXT_MODE=0), the select byte is {4'b1010, req_addr[10:8], rw} with rw in bit 0 (0 = write, 1 = read). Exactly one address byte follows, req_addr[7:0].
- R3: In extended mode (EXT_MODE=1), the select byte is {4'b1010, HW_SEL[2:0], rw}. It is followed by req_addr[15:8] and then req_addr[7:0].
- R4: Engine opcodes on cmd_op are 0 = START, 1 = transmit cmd_byte, 2 = receive, 3 = STOP. A write issues START, the select byte with rw=0, the address bytes, req_wdata, and then STOP.
- R5: A read issues the same write-mode address phase, then START (a repeated start), then the select byte with rw=1, then req_len+1 receive commands, then STOP.
- R6: On each receive command, cmd_ack is 1 (the master acknowledges) except on the final receive, where it is 0. On every other command cmd_ack is 0.
- R7: Each received byte appears on rd_data with rd_valid high for exactly one cycle, in the order it was received.
- R8: If eng_nack is 1 when a transmit command completes, the very next command is STOP, no further byte is sent or received, and err is 1 when done pulses.
- R9: err stays at 1 after a failed transaction until the next accepted request, which clears it.
- R10: A req_start that arrives while busy is 1 is ignored. The current command sequence continues unchanged.
- R11: At most one engine command is outstanding. cmd_valid is a one-cycle pulse, and no new command is issued until eng_done reports completion.
- R12: When the final STOP completes, done pulses for one cycle and busy is 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Request strobe, accepted only when idle |
| req_write | input | 1 | 1 = write one byte, 0 = read |
| req_addr | input | ADDR_W | Memory address (11 bits compact, 16 bits extended) |
| req_wdata | input | 8 | Byte to write |
| req_len | input | LEN_W | Read length minus one |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at transaction end |
| err | output | 1 | Last transaction was refused by the device |
| rd_valid | output | 1 | rd_data holds a new received byte |
| rd_data | output | 8 | Received byte |
| cmd_valid | output | 1 | Issue a command to the byte engine |
| cmd_op | output | 2 | Command opcode |
| cmd_byte | output | 8 | Byte to transmit |
| cmd_ack | output | 1 | Acknowledge to drive after a received byte |
| eng_done | input | 1 | Engine finished the outstanding command |
| eng_nack | input | 1 | Device refused the transmitted byte (valid with eng_done) |
| eng_rbyte | input | 8 | Received byte (valid with eng_done) |

## Verification
The hardest situations to reach are device refusals at each separate stage of a transaction: the select byte, the address byte, the data byte, and the read-mode select byte after the repeated START. Each stage shifts the abort point, and the position of every stage also depends on the addressing mode. The bench models the byte engine in both modes side by side. Its table names the stage to refuse rather than a fixed command index, and the model converts that stage into the index that matches each mode. A request strobe is also injected in the middle of a busy transaction to confirm it is ignored.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_WRITE = 2'd1,
      OP_READ  = 2'd2,
      OP_STOP  = 2'd3
   } bus_op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_START,
      ST_DEVW,
      ST_AHI,
      ST_ALO,
      ST_DATA,
      ST_RSTART,
      ST_DEVR,
      ST_READ,
      ST_STOP
   } seq_state_e;

   localparam logic [3:0] DEV_BASE = 4'b1010;

   function automatic int addr_width(input int ext_mode);
      return (ext_mode != 0) ? 16 : 11;
   endfunction

endpackage

// File: rtl/eeprom_addr_map.sv
module eeprom_addr_map
   import eeprom_seq_pkg::*;
#(
   parameter int EXT_MODE = 0,
   parameter int HW_SEL   = 0,
   parameter int ADDR_W   = addr_width(EXT_MODE)
) (
   input  logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        sel_wr,
   output logic [7:0]        sel_rd,
   output logic [7:0]        hi_byte,
   output logic [7:0]        lo_byte
);

   localparam logic [2:0] CHIP_SEL = HW_SEL[2:0];

   logic [2:0] mid_bits;

   generate
      if (EXT_MODE != 0) begin : g_extended
         assign mid_bits = CHIP_SEL;
         assign hi_byte  = mem_addr[15:8];
      end else begin : g_compact
         assign mid_bits = mem_addr[10:8];
         assign hi_byte  = 8'h00;
      end
   endgenerate

   assign lo_byte = mem_addr[7:0];
   assign sel_wr  = {DEV_BASE, mid_bits, 1'b0};
   assign sel_rd  = {DEV_BASE, mid_bits, 1'b1};

endmodule

// File: rtl/eeprom_rd_counter.sv
module eeprom_rd_counter #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] load_val,
   input  logic             dec,
   output logic             last
);

   logic [LEN_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (load) begin
         remain <= load_val;
      end else if (dec && (remain != '0)) begin
         remain <= remain - 1'b1;
      end
   end

   assign last = (remain == '0);

   AST_LAST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !load) |=> last); // R6

endmodule

// File: rtl/eeprom_seq_ctrl.sv
module eeprom_seq_ctrl
   import eeprom_seq_pkg::*;
#(
   parameter int EXT_MODE = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_start,
   input  logic       req_write,
   output logic       accept,
   input  logic [7:0] sel_wr,
   input  logic [7:0] sel_rd,
   input  logic [7:0] hi_byte,
   input  logic [7:0] lo_byte,
   input  logic [7:0] wdata,
   input  logic       last,
   output logic       cnt_dec,
   output logic       busy,
   output logic       done,
   output logic       err,
   output logic       rd_valid,
   output logic [7:0] rd_data,
   output logic       cmd_valid,
   output logic [1:0] cmd_op,
   output logic [7:0] cmd_byte,
   output logic       cmd_ack,
   input  logic       eng_done,
   input  logic       eng_nack,
   input  logic [7:0] eng_rbyte
);

   localparam bit HAS_HI = (EXT_MODE != 0);

   seq_state_e state, nxt;
   bus_op_e    op;
   logic       pend;
   logic       wr_q;
   logic       step;
   logic       nack_hit;

   assign busy      = (state != ST_IDLE);
   assign accept    = req_start && (state == ST_IDLE);
   assign cmd_valid = busy && !pend;
   assign step      = pend && eng_done;
   assign nack_hit  = step && eng_nack && (op == OP_WRITE);
   assign cnt_dec   = step && (state == ST_READ) && !last;

   always_comb begin
      op       = OP_START;
      cmd_byte = 8'h00;
      cmd_ack  = 1'b0;
      unique case (state)
         ST_START, ST_RSTART: op = OP_START;
         ST_DEVW:  begin op = OP_WRITE; cmd_byte = sel_wr;  end
         ST_AHI:   begin op = OP_WRITE; cmd_byte = hi_byte; end
         ST_ALO:   begin op = OP_WRITE; cmd_byte = lo_byte; end
         ST_DATA:  begin op = OP_WRITE; cmd_byte = wdata;   end
         ST_DEVR:  begin op = OP_WRITE; cmd_byte = sel_rd;  end
         ST_READ:  begin op = OP_READ;  cmd_ack  = !last;   end
         ST_STOP:  op = OP_STOP;
         default:  op = OP_START;
      endcase
   end

   assign cmd_op = op;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_START:  nxt = ST_DEVW;
         ST_DEVW:   nxt = eng_nack ? ST_STOP : (HAS_HI ? ST_AHI : ST_ALO);
         ST_AHI:    nxt = eng_nack ? ST_STOP : ST_ALO;
         ST_ALO:    nxt = eng_nack ? ST_STOP : (wr_q ? ST_DATA : ST_RSTART);
         ST_DATA:   nxt = ST_STOP;
         ST_RSTART: nxt = ST_DEVR;
         ST_DEVR:   nxt = eng_nack ? ST_STOP : ST_READ;
         ST_READ:   nxt = last ? ST_STOP : ST_READ;
         ST_STOP:   nxt = ST_IDLE;
         default:   nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         pend     <= 1'b0;
         wr_q     <= 1'b0;
         err      <= 1'b0;
         done     <= 1'b0;
         rd_valid <= 1'b0;
         rd_data  <= 8'h00;
      end else begin
         done     <= 1'b0;
         rd_valid <= 1'b0;
         if (accept) begin
            state <= ST_START;
            pend  <= 1'b0;
            wr_q  <= req_write;
            err   <= 1'b0;
         end else if (cmd_valid) begin
            pend <= 1'b1;
         end else if (step) begin
            pend  <= 1'b0;
            state <= nxt;
            if (nack_hit) begin
               err <= 1'b1;
            end
            if (state == ST_READ) begin
               rd_valid <= 1'b1;
               rd_data  <= eng_rbyte;
            end
            if (state == ST_STOP) begin
               done <= 1'b1;
            end
         end
      end
   end

   AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid); // R11
   AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      nack_hit |=> (cmd_valid && (cmd_op == OP_STOP))); // R8
   AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R7
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R12

endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq
   import eeprom_seq_pkg::*;
#(
   parameter int EXT_MODE = 0,
   parameter int HW_SEL   = 0,
   parameter int LEN_W    = 8,
   localparam int ADDR_W  = addr_width(EXT_MODE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_wdata,
   input  logic [LEN_W-1:0]  req_len,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic              cmd_valid,
   output logic [1:0]        cmd_op,
   output logic [7:0]        cmd_byte,
   output logic              cmd_ack,
   input  logic              eng_done,
   input  logic              eng_nack,
   input  logic [7:0]        eng_rbyte
);

   generate
      if (EXT_MODE != 0 && EXT_MODE != 1) begin : g_bad_mode
         $error("EXT_MODE must be 0 or 1");
      end
      if (HW_SEL < 0 || HW_SEL > 7) begin : g_bad_sel
         $error("HW_SEL must fit in three bits");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("LEN_W must be between 1 and 16");
      end
   endgenerate

   logic              accept;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        wdata_q;
   logic [7:0]        sel_wr, sel_rd, hi_byte, lo_byte;
   logic              last, cnt_dec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= 8'h00;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   eeprom_addr_map #(
      .EXT_MODE (EXT_MODE),
      .HW_SEL   (HW_SEL),
      .ADDR_W   (ADDR_W)
   ) i_addr_map (
      .mem_addr (addr_q),
      .sel_wr   (sel_wr),
      .sel_rd   (sel_rd),
      .hi_byte  (hi_byte),
      .lo_byte  (lo_byte)
   );

   eeprom_rd_counter #(
      .LEN_W (LEN_W)
   ) i_rd_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (req_len),
      .dec      (cnt_dec),
      .last     (last)
   );

   eeprom_seq_ctrl #(
      .EXT_MODE (EXT_MODE)
   ) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_start (req_start),
      .req_write (req_write),
      .accept    (accept),
      .sel_wr    (sel_wr),
      .sel_rd    (sel_rd),
      .hi_byte   (hi_byte),
      .lo_byte   (lo_byte),
      .wdata     (wdata_q),
      .last      (last),
      .cnt_dec   (cnt_dec),
      .busy      (busy),
      .done      (done),
      .err       (err),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_byte  (cmd_byte),
      .cmd_ack   (cmd_ack),
      .eng_done  (eng_done),
      .eng_nack  (eng_nack),
      .eng_rbyte (eng_rbyte)
   );

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (busy && cmd_valid && (cmd_op == 2'd0))); // R4

endmodule

// File: tb/test_eeprom_seq.sv
`timescale 1ns/1ps
module test_eeprom_seq;

   localparam int MAXL = 64;
   // {write, addr[15:0], wdata, len, refuse stage}
   // stage: 0 none, 1 select(W), 2 low address, 3 data, 4 select(R)
   localparam int NV = 8;
   localparam logic [40:0] VECS [NV] = '{
      {1'b1, 16'h35A7, 8'h5C, 8'd0, 8'd0},
      {1'b0, 16'h0712, 8'h00, 8'd3, 8'd0},
      {1'b0, 16'hFFFF, 8'h00, 8'd0, 8'd0},
      {1'b1, 16'h0401, 8'hE1, 8'd0, 8'd3},
      {1'b0, 16'h1234, 8'h00, 8'd2, 8'd4},
      {1'b1, 16'h0000, 8'h00, 8'd0, 8'd1},
      {1'b0, 16'h2BCD, 8'h00, 8'd7, 8'd0},
      {1'b0, 16'h6E09, 8'h00, 8'd1, 8'd2}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        req_start = 1'b0;
   logic        req_write = 1'b0;
   logic [15:0] req_addr  = 16'h0;
   logic [7:0]  req_wdata = 8'h0;
   logic [7:0]  req_len   = 8'h0;

   logic       busy_s [2];
   logic       done_s [2];
   logic       err_s [2];
   logic       rdv_s [2];
   logic [7:0] rdd_s [2];
   logic       cv_s [2];
   logic [1:0] op_s [2];
   logic [7:0] cb_s [2];
   logic       ca_s [2];
   logic       ed_s [2];
   logic       en_s [2];
   logic [7:0] er_s [2];

   eeprom_seq #(.EXT_MODE(0), .HW_SEL(0), .LEN_W(8)) i_eeprom_seq (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
      .req_addr(req_addr[10:0]), .req_wdata(req_wdata), .req_len(req_len),
      .busy(busy_s[0]), .done(done_s[0]), .err(err_s[0]), .rd_valid(rdv_s[0]),
      .rd_data(rdd_s[0]), .cmd_valid(cv_s[0]), .cmd_op(op_s[0]), .cmd_byte(cb_s[0]),
      .cmd_ack(ca_s[0]), .eng_done(ed_s[0]), .eng_nack(en_s[0]), .eng_rbyte(er_s[0]));

   eeprom_seq #(.EXT_MODE(1), .HW_SEL(5), .LEN_W(8)) i_eeprom_seq_ext (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
      .busy(busy_s[1]), .done(done_s[1]), .err(err_s[1]), .rd_valid(rdv_s[1]),
      .rd_data(rdd_s[1]), .cmd_valid(cv_s[1]), .cmd_op(op_s[1]), .cmd_byte(cb_s[1]),
      .cmd_ack(ca_s[1]), .eng_done(ed_s[1]), .eng_nack(en_s[1]), .eng_rbyte(er_s[1]));

   int n_chk = 0;
   int n_bad = 0;

   logic [10:0] lg [2][MAXL];
   int          lc [2];
   logic [7:0]  rlog [2][MAXL];
   int          rc [2];
   int          nk [2];
   int          viol [2];
   logic        done_seen [2];
   logic        err_done [2];
   logic        busy_done [2];

   logic [10:0] exq [2][MAXL];
   string       etag [2][MAXL];
   int          ec [2];
   logic        ex_abort [2];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   for (genvar m = 0; m < 2; m++) begin : g_eng
      initial begin
         ed_s[m] = 1'b0; en_s[m] = 1'b0; er_s[m] = 8'h00;
         lc[m] = 0; viol[m] = 0;
         @(negedge clk);
         forever begin
            if (cv_s[m]) begin
               int k;
               logic [1:0] o;
               k = lc[m];
               o = op_s[m];
               if (k < MAXL) lg[m][k] = {op_s[m], ca_s[m], cb_s[m]};
               lc[m] = k + 1;
               repeat (2) begin
                  @(negedge clk);
                  if (cv_s[m]) viol[m]++;
               end
               en_s[m] = (k == nk[m]) && (o == 2'd1);
               er_s[m] = 8'hA0 ^ k[7:0];
               ed_s[m] = 1'b1;
               @(negedge clk);
               ed_s[m] = 1'b0;
               en_s[m] = 1'b0;
            end else begin
               @(negedge clk);
            end
         end
      end
      initial begin
         rc[m] = 0; done_seen[m] = 1'b0; err_done[m] = 1'b0; busy_done[m] = 1'b0;
         forever begin
            @(negedge clk);
            if (rdv_s[m]) begin
               if (rc[m] < MAXL) rlog[m][rc[m]] = rdd_s[m];
               rc[m]++;
            end
            if (done_s[m]) begin
               done_seen[m] = 1'b1;
               err_done[m]  = err_s[m];
               busy_done[m] = busy_s[m];
            end
         end
      end
   end

   function automatic int stage_idx(input int m, input int stage);
      case (stage)
         1: return 1;
         2: return (m != 0) ? 3 : 2;
         3: return (m != 0) ? 4 : 3;
         4: return (m != 0) ? 5 : 4;
         default: return 999;
      endcase
   endfunction

   task automatic push(input int m, input logic [1:0] op, input logic ack,
                       input logic [7:0] b, input string tag);
      if (!ex_abort[m]) begin
         exq[m][ec[m]]  = {op, ack, b};
         etag[m][ec[m]] = tag;
         if (ec[m] == nk[m] && op == 2'd1) begin
            ex_abort[m] = 1'b1;
            ec[m]++;
            exq[m][ec[m]]  = {2'd3, 1'b0, 8'h00};
            etag[m][ec[m]] = "R8";
         end
         ec[m]++;
      end
   endtask

   task automatic build(input int m, input logic wr, input logic [15:0] a,
                        input logic [7:0] wd, input int len);
      logic [2:0] sel;
      string      at;
      sel = (m != 0) ? 3'b101 : a[10:8];
      at  = (m != 0) ? "R3" : "R2";
      ec[m] = 0;
      ex_abort[m] = 1'b0;
      push(m, 2'd0, 1'b0, 8'h00, wr ? "R4" : "R5");
      push(m, 2'd1, 1'b0, {4'b1010, sel, 1'b0}, at);
      if (m != 0) push(m, 2'd1, 1'b0, a[15:8], at);
      push(m, 2'd1, 1'b0, a[7:0], at);
      if (wr) begin
         push(m, 2'd1, 1'b0, wd, "R4");
         push(m, 2'd3, 1'b0, 8'h00, "R4");
      end else begin
         push(m, 2'd0, 1'b0, 8'h00, "R5");
         push(m, 2'd1, 1'b0, {4'b1010, sel, 1'b1}, "R5");
         for (int i = 0; i <= len; i++) push(m, 2'd2, (i < len), 8'h00, "R6");
         push(m, 2'd3, 1'b0, 8'h00, "R5");
      end
   endtask

   task automatic run(input logic [40:0] v, input bit poke);
      logic       wr;
      logic [15:0] a;
      logic [7:0] wd;
      int         len, stage, t;
      wr = v[40]; a = v[39:24]; wd = v[23:16]; len = int'(v[15:8]); stage = int'(v[7:0]);
      for (int m = 0; m < 2; m++) begin
         nk[m] = stage_idx(m, stage);
         build(m, wr, a, wd, len);
         lc[m] = 0; rc[m] = 0; viol[m] = 0; done_seen[m] = 1'b0;
      end
      @(negedge clk);
      req_write = wr; req_addr = a; req_wdata = wd; req_len = v[15:8]; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      if (poke) begin
         repeat (5) @(negedge clk);
         req_write = ~wr; req_addr = ~a; req_wdata = ~wd; req_len = 8'd5; req_start = 1'b1;
         @(negedge clk);
         req_start = 1'b0;
      end
      t = 0;
      while (!(done_seen[0] && done_seen[1]) && t < 3000) begin
         @(negedge clk);
         t++;
      end
      chk("R12 done seen", {31'b0, done_seen[0] && done_seen[1]}, 32'd1);
      for (int m = 0; m < 2; m++) begin
         chk(ex_abort[m] ? "R8 cmd count" : (poke ? "R10 cmd count" : "R4 R5 cmd count"),
             lc[m], ec[m]);
         for (int k = 0; k < ec[m] && k < lc[m]; k++)
            chk(poke ? "R10" : etag[m][k], {21'b0, lg[m][k]}, {21'b0, exq[m][k]});
         chk("R7 read count", rc[m], (ex_abort[m] || wr) ? 0 : len + 1);
         if (!ex_abort[m] && !wr)
            for (int i = 0; i <= len && i < rc[m]; i++)
               chk("R7 read byte", {24'b0, rlog[m][i]},
                   {24'b0, 8'hA0 ^ 8'((m != 0 ? 6 : 5) + i)});
         chk(ex_abort[m] ? "R8 err" : "R9 err cleared", {31'b0, err_done[m]},
             {31'b0, ex_abort[m]});
         chk("R11 one outstanding", viol[m], 0);
         chk("R12 busy low at done", {31'b0, busy_done[m]}, 32'd0);
      end
      if (ex_abort[0]) begin
         repeat (5) @(negedge clk);
         chk("R9 err held", {31'b0, err_s[0]}, 32'd1);
         chk("R9 err held", {31'b0, err_s[1]}, 32'd1);
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      nk[0] = 999; nk[1] = 999;
      repeat (3) @(negedge clk);
      for (int m = 0; m < 2; m++) begin
         chk("R1 busy in reset", {31'b0, busy_s[m]}, 32'd0);
         chk("R1 cmd_valid in reset", {31'b0, cv_s[m]}, 32'd0);
      end
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      for (int m = 0; m < 2; m++) begin
         chk("R1 busy", {31'b0, busy_s[m]}, 32'd0);
         chk("R1 done", {31'b0, done_s[m]}, 32'd0);
         chk("R1 err", {31'b0, err_s[m]}, 32'd0);
         chk("R1 rd_valid", {31'b0, rdv_s[m]}, 32'd0);
         chk("R1 cmd_valid", {31'b0, cv_s[m]}, 32'd0);
      end
      for (int i = 0; i < NV; i++) run(VECS[i], 1'b0);
      // R10: second request strobe during a busy read
      run({1'b0, 16'h0155, 8'h00, 8'd1, 8'd0}, 1'b1);
      // R9: refused write, then a clean write clears err
      run({1'b1, 16'h0203, 8'h77, 8'd0, 8'd2}, 1'b0);
      run({1'b1, 16'h0203, 8'h77, 8'd0, 8'd0}, 1'b0);
      summary();
      $finish;
   end

endmodule